// File: doc/BRIEF.md
# Dual-Slot Issue Steering with Unit Reservation

This block sits at the issue stage of a small in-order superscalar core. Each cycle it may be offered two dispatch-slot instructions (an older slot 0 and a younger slot 1) and one side-lane instruction. Dispatch-slot instructions go to the integer, load/store or floating-point units. Side-lane instructions are branches or system-register operations and never use a dispatch slot. The block decodes a class tag per instruction, picks the executing unit, and reports the unit code and result latency for every lane that issues.

Every unit that can be held for more than one cycle has a busy counter. An instruction whose unit is held, or already claimed by the older slot in the same cycle, does not issue. Issue is strictly in order across the two slots. The two integer units are not equal: only the first accepts multiply and divide, so single integer work is steered to the second unit whenever it is free. Long divide lengths and the system-unit hold are parameters.

Top module: `dual_issue_reserve`

## Requirements
- R1: After a synchronous active-high reset, no unit is held, so any lane presented alone issues at once, and with no valid input nothing issues and stall is low.
- R2: Slot class codes: 0 simple integer (latency 1), 1 integer compare (2), 2 full multiply (4), 3 medium multiply (3), 4 short multiply (2), 5 integer divide (IDIV_CYC), 6 two-cycle integer (1), 7 three-cycle integer (1), 8 load/store (2), 9 conditional store (8), 10 float op (3), 11 float compare (2), 12 single divide (SDIV_CYC), 13 double divide (DDIV_CYC). An issued slot reports that latency and a unit code: 0 first integer, 1 second integer, 2 load/store, 3 float, 4 system, 5 branch.
- R3: An instruction that either integer unit may take (codes 0, 1, 6, 7) goes to unit 1 when it is free, and otherwise to unit 0.
- R4: Codes 2 to 5 issue only to unit 0.
- R5: An issued instruction holds its unit for a class-specific count H that includes the issue cycle: 4, 2 and 1 for codes 2, 3 and 4; IDIV_CYC for 5; 2 and 3 for codes 6 and 7; SDIV_CYC and DDIV_CYC for 12 and 13. The unit accepts again H cycles after issue.
- R6: Codes 0, 1, 8, 9, 10 and 11 hold their unit for one cycle only, so the same unit accepts again on the next cycle.
- R7: Two slots that need the same unit (and have no free alternative) in one cycle: slot 0 issues and slot 1 does not.
- R8: Slot 1 issues only if slot 0 issues or slot 0 is empty in that cycle.
- R9: Side-lane codes: 0 branch (unit 5, latency 1, always issues), 1 condition-logic op (latency 3), 2 move to special register (latency 2), 3 move from special register (latency 3). Codes 1 to 3 use unit 4 and hold it for SRU_CYC cycles.
- R10: stall is high exactly when some valid lane does not issue in that cycle.
- R11: A lane that does not issue shows unit code 0 and latency 0.
- R12: Slot class codes 14 and 15 behave as a simple integer instruction (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot0_vld | input | 1 | Older dispatch slot holds an instruction |
| slot0_cls | input | 4 | Class code of slot 0 |
| slot1_vld | input | 1 | Younger dispatch slot holds an instruction |
| slot1_cls | input | 4 | Class code of slot 1 |
| side_vld | input | 1 | Side lane holds an instruction |
| side_cls | input | 2 | Class code of the side lane |
| slot0_iss | output | 1 | Slot 0 issues this cycle |
| slot0_unit | output | 3 | Unit chosen for slot 0 |
| slot0_lat | output | 6 | Result latency of slot 0 |
| slot1_iss | output | 1 | Slot 1 issues this cycle |
| slot1_unit | output | 3 | Unit chosen for slot 1 |
| slot1_lat | output | 6 | Result latency of slot 1 |
| side_iss | output | 1 | Side lane issues this cycle |
| side_unit | output | 3 | Unit chosen for the side lane |
| side_lat | output | 6 | Result latency of the side lane |
| stall | output | 1 | A valid lane is held back this cycle |

## Verification
The bench builds the block with IDIV_CYC=7, SDIV_CYC=5, DDIV_CYC=9 and SRU_CYC=2. These short divide holds let every ordered pair of the sixteen slot classes be tried from an idle start. They also let every class be probed with a same-unit follower at each offset from one cycle up to one past its hold. The first free cycle of each reservation and the steering between the two integer units are therefore seen for every class, together with the side lane's system-unit hold.

// File: rtl/issue_pkg.sv
package issue_pkg;

    localparam int LAT_W   = 6;
    localparam int NUM_TRK = 5;

    typedef enum logic [3:0] {
        OP_INT   = 4'd0,  OP_CMP   = 4'd1,  OP_MULF  = 4'd2,  OP_MULM = 4'd3,
        OP_MULS  = 4'd4,  OP_DIV   = 4'd5,  OP_TWO   = 4'd6,  OP_THREE = 4'd7,
        OP_LDST  = 4'd8,  OP_STCX  = 4'd9,  OP_FP    = 4'd10, OP_FCMP = 4'd11,
        OP_SDIV  = 4'd12, OP_DDIV  = 4'd13, OP_RSV14 = 4'd14, OP_RSV15 = 4'd15
    } op_cls_e;

    typedef enum logic [1:0] {
        SD_BRANCH = 2'd0, SD_CRLOG = 2'd1, SD_MTSPR = 2'd2, SD_MFSPR = 2'd3
    } side_cls_e;

    typedef enum logic [2:0] {
        U_IU1 = 3'd0, U_IU2 = 3'd1, U_LSU = 3'd2, U_FPU = 3'd3, U_SRU = 3'd4, U_BPU = 3'd5
    } unit_e;

    typedef enum logic [1:0] {
        K_INT_ANY = 2'd0, K_INT_FIRST = 2'd1, K_MEM = 2'd2, K_FLT = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [LAT_W-1:0] hold;
        logic [LAT_W-1:0] lat;
    } op_info_t;

    typedef struct packed {
        logic             iss;
        unit_e            unit;
        logic [LAT_W-1:0] lat;
    } grant_t;

    function automatic op_info_t mk_info(kind_e k, int h, int l);
        op_info_t r;
        r.kind = k;
        r.hold = LAT_W'(h);
        r.lat  = LAT_W'(l);
        return r;
    endfunction

    function automatic logic [LAT_W-1:0] side_latency(side_cls_e c);
        case (c)
            SD_BRANCH: return LAT_W'(1);
            SD_MTSPR:  return LAT_W'(2);
            default:   return LAT_W'(3);
        endcase
    endfunction

    // Chooses a unit for one slot out of the units still available to it.
    function automatic grant_t pick_unit(logic want, kind_e k,
                                         logic [NUM_TRK-1:0] avail,
                                         logic [LAT_W-1:0] lat);
        grant_t g;
        g.iss  = 1'b0;
        g.unit = U_IU1;
        g.lat  = '0;
        if (want) begin
            case (k)
                K_INT_ANY: begin
                    if (avail[1]) begin
                        g.iss  = 1'b1;
                        g.unit = U_IU2;
                    end else begin
                        g.iss  = avail[0];
                    end
                end
                K_INT_FIRST: g.iss = avail[0];
                K_MEM: begin
                    g.iss  = avail[2];
                    g.unit = U_LSU;
                end
                default: begin
                    g.iss  = avail[3];
                    g.unit = U_FPU;
                end
            endcase
        end
        if (g.iss) g.lat = lat;
        else       g.unit = U_IU1;
        return g;
    endfunction

endpackage

// File: rtl/issue_class_decode.sv
module issue_class_decode
    import issue_pkg::*;
#(
    parameter int IDIV_CYC = 19,
    parameter int SDIV_CYC = 17,
    parameter int DDIV_CYC = 31
) (
    input  logic [3:0] cls_i,
    output op_info_t   info_o
);

    always_comb begin
        case (op_cls_e'(cls_i))
            OP_CMP:   info_o = mk_info(K_INT_ANY,   1, 2);
            OP_MULF:  info_o = mk_info(K_INT_FIRST, 4, 4);
            OP_MULM:  info_o = mk_info(K_INT_FIRST, 2, 3);
            OP_MULS:  info_o = mk_info(K_INT_FIRST, 1, 2);
            OP_DIV:   info_o = mk_info(K_INT_FIRST, IDIV_CYC, IDIV_CYC);
            OP_TWO:   info_o = mk_info(K_INT_ANY,   2, 1);
            OP_THREE: info_o = mk_info(K_INT_ANY,   3, 1);
            OP_LDST:  info_o = mk_info(K_MEM,       1, 2);
            OP_STCX:  info_o = mk_info(K_MEM,       1, 8);
            OP_FP:    info_o = mk_info(K_FLT,       1, 3);
            OP_FCMP:  info_o = mk_info(K_FLT,       1, 2);
            OP_SDIV:  info_o = mk_info(K_FLT,       SDIV_CYC, SDIV_CYC);
            OP_DDIV:  info_o = mk_info(K_FLT,       DDIV_CYC, DDIV_CYC);
            default:  info_o = mk_info(K_INT_ANY,   1, 1);
        endcase
    end

endmodule

// File: rtl/issue_unit_busy.sv
module issue_unit_busy
    import issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             book_i,
    input  logic [LAT_W-1:0] hold_i,
    output logic             free_o
);

    logic [LAT_W-1:0] left_q;

    // left_q counts the cycles still held after the current one.
    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (book_i)        left_q <= hold_i - LAT_W'(1);
        else if (left_q != '0)  left_q <= left_q - LAT_W'(1);
    end

    assign free_o = (left_q == '0);

endmodule

// File: rtl/issue_slot_select.sv
module issue_slot_select
    import issue_pkg::*;
(
    input  logic               slot0_vld,
    input  logic               slot1_vld,
    input  op_info_t           info0,
    input  op_info_t           info1,
    input  logic [NUM_TRK-1:0] unit_free,
    output grant_t             grant0,
    output grant_t             grant1
);

    logic [NUM_TRK-1:0] taken0;
    logic               go1;

    assign grant0 = pick_unit(slot0_vld, info0.kind, unit_free, info0.lat);
    assign taken0 = grant0.iss ? (NUM_TRK'(1) << grant0.unit) : '0;
    assign go1    = slot1_vld && (!slot0_vld || grant0.iss);
    assign grant1 = pick_unit(go1, info1.kind, unit_free & ~taken0, info1.lat);

endmodule

// File: rtl/dual_issue_reserve.sv
module dual_issue_reserve
    import issue_pkg::*;
#(
    parameter int IDIV_CYC = 19,
    parameter int SDIV_CYC = 17,
    parameter int DDIV_CYC = 31,
    parameter int SRU_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot0_vld,
    input  logic [3:0] slot0_cls,
    input  logic       slot1_vld,
    input  logic [3:0] slot1_cls,
    input  logic       side_vld,
    input  logic [1:0] side_cls,
    output logic       slot0_iss,
    output logic [2:0] slot0_unit,
    output logic [5:0] slot0_lat,
    output logic       slot1_iss,
    output logic [2:0] slot1_unit,
    output logic [5:0] slot1_lat,
    output logic       side_iss,
    output logic [2:0] side_unit,
    output logic [5:0] side_lat,
    output logic       stall
);

    localparam logic [LAT_W-1:0] SRU_HOLD = LAT_W'(SRU_CYC);
    localparam int               SRU_IDX  = int'(U_SRU);

    op_info_t           info0, info1;
    grant_t             g0, g1;
    logic [NUM_TRK-1:0] unit_free;
    side_cls_e          scls;
    logic               side_br;
    unit_e              side_u;

    issue_class_decode #(.IDIV_CYC(IDIV_CYC), .SDIV_CYC(SDIV_CYC), .DDIV_CYC(DDIV_CYC))
        u_dec0 (.cls_i(slot0_cls), .info_o(info0));
    issue_class_decode #(.IDIV_CYC(IDIV_CYC), .SDIV_CYC(SDIV_CYC), .DDIV_CYC(DDIV_CYC))
        u_dec1 (.cls_i(slot1_cls), .info_o(info1));

    issue_slot_select u_sel (
        .slot0_vld (slot0_vld),
        .slot1_vld (slot1_vld),
        .info0     (info0),
        .info1     (info1),
        .unit_free (unit_free),
        .grant0    (g0),
        .grant1    (g1)
    );

    // Side lane: branches never wait, system ops wait on the system unit.
    assign scls     = side_cls_e'(side_cls);
    assign side_br  = (scls == SD_BRANCH);
    assign side_iss = side_vld && (side_br || unit_free[SRU_IDX]);
    assign side_u   = side_br ? U_BPU : U_SRU;
    assign side_unit = side_iss ? side_u : U_IU1;
    assign side_lat  = side_iss ? side_latency(scls) : '0;

    for (genvar u = 0; u < NUM_TRK; u++) begin : g_trk
        logic             book;
        logic [LAT_W-1:0] hold;
        always_comb begin
            book = 1'b0;
            hold = '0;
            if (g0.iss && g0.unit == unit_e'(3'(u))) begin
                book = 1'b1;
                hold = info0.hold;
            end else if (g1.iss && g1.unit == unit_e'(3'(u))) begin
                book = 1'b1;
                hold = info1.hold;
            end else if (side_iss && side_u == unit_e'(3'(u))) begin
                book = 1'b1;
                hold = SRU_HOLD;
            end
        end
        issue_unit_busy u_busy (
            .clk    (clk),
            .rst    (rst),
            .book_i (book),
            .hold_i (hold),
            .free_o (unit_free[u])
        );
    end

    assign slot0_iss  = g0.iss;
    assign slot0_unit = g0.unit;
    assign slot0_lat  = g0.lat;
    assign slot1_iss  = g1.iss;
    assign slot1_unit = g1.unit;
    assign slot1_lat  = g1.lat;

    assign stall = (slot0_vld && !g0.iss) || (slot1_vld && !g1.iss) || (side_vld && !side_iss);

endmodule

// File: rtl/dual_issue_reserve_chk.sv
module dual_issue_reserve_chk (
    input logic       clk,
    input logic       rst,
    input logic       slot0_vld,
    input logic [3:0] slot0_cls,
    input logic       slot1_vld,
    input logic [3:0] slot1_cls,
    input logic       side_vld,
    input logic [1:0] side_cls,
    input logic       slot0_iss,
    input logic [2:0] slot0_unit,
    input logic [5:0] slot0_lat,
    input logic       slot1_iss,
    input logic [2:0] slot1_unit,
    input logic [5:0] slot1_lat,
    input logic       side_iss,
    input logic [2:0] side_unit,
    input logic [5:0] side_lat,
    input logic       stall
);

    logic md0, md1;
    assign md0 = (slot0_cls >= 4'd2) && (slot0_cls <= 4'd5);
    assign md1 = (slot1_cls >= 4'd2) && (slot1_cls <= 4'd5);

    assert_in_order_R8: assert property (@(posedge clk) disable iff (rst)
        slot1_iss |-> (slot0_iss || !slot0_vld));

    assert_distinct_units_R7: assert property (@(posedge clk) disable iff (rst)
        (slot0_iss && slot1_iss) |-> (slot0_unit != slot1_unit));

    assert_first_only_s0_R4: assert property (@(posedge clk) disable iff (rst)
        (slot0_iss && md0) |-> (slot0_unit == 3'd0));

    assert_first_only_s1_R4: assert property (@(posedge clk) disable iff (rst)
        (slot1_iss && md1) |-> (slot1_unit == 3'd0));

    assert_div_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (slot0_iss && slot0_cls == 4'd5) |=>
            !(slot0_iss && slot0_unit == 3'd0) && !(slot1_iss && slot1_unit == 3'd0));

    assert_branch_free_R9: assert property (@(posedge clk) disable iff (rst)
        (side_vld && side_cls == 2'd0) |-> (side_iss && side_unit == 3'd5 && side_lat == 6'd1));

    assert_older_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (slot0_vld && !slot0_iss) |-> (stall && !slot1_iss));

    assert_younger_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (slot1_vld && !slot1_iss) |-> stall);

    assert_idle_fields_R11: assert property (@(posedge clk) disable iff (rst)
        !slot1_iss |-> (slot1_unit == 3'd0 && slot1_lat == 6'd0));

    assert_latency_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        slot0_iss |-> (slot0_lat != 6'd0));

endmodule

bind dual_issue_reserve dual_issue_reserve_chk u_chk (
    .clk(clk), .rst(rst),
    .slot0_vld(slot0_vld), .slot0_cls(slot0_cls),
    .slot1_vld(slot1_vld), .slot1_cls(slot1_cls),
    .side_vld(side_vld), .side_cls(side_cls),
    .slot0_iss(slot0_iss), .slot0_unit(slot0_unit), .slot0_lat(slot0_lat),
    .slot1_iss(slot1_iss), .slot1_unit(slot1_unit), .slot1_lat(slot1_lat),
    .side_iss(side_iss), .side_unit(side_unit), .side_lat(side_lat),
    .stall(stall)
);

// File: tb/dual_issue_reserve_tb.sv
module dual_issue_reserve_tb;

    localparam int IDIV = 7;
    localparam int SDIV = 5;
    localparam int DDIV = 9;
    localparam int SRUC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot0_vld = 1'b0, slot1_vld = 1'b0, side_vld = 1'b0;
    logic [3:0] slot0_cls = '0, slot1_cls = '0;
    logic [1:0] side_cls = '0;
    logic       slot0_iss, slot1_iss, side_iss, stall;
    logic [2:0] slot0_unit, slot1_unit, side_unit;
    logic [5:0] slot0_lat, slot1_lat, side_lat;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_issue_reserve #(.IDIV_CYC(IDIV), .SDIV_CYC(SDIV), .DDIV_CYC(DDIV), .SRU_CYC(SRUC)) u_dut (
        .clk(clk), .rst(rst),
        .slot0_vld(slot0_vld), .slot0_cls(slot0_cls),
        .slot1_vld(slot1_vld), .slot1_cls(slot1_cls),
        .side_vld(side_vld), .side_cls(side_cls),
        .slot0_iss(slot0_iss), .slot0_unit(slot0_unit), .slot0_lat(slot0_lat),
        .slot1_iss(slot1_iss), .slot1_unit(slot1_unit), .slot1_lat(slot1_lat),
        .side_iss(side_iss), .side_unit(side_unit), .side_lat(side_lat),
        .stall(stall)
    );

    // Expected class properties, from the requirement text.
    function automatic int e_lat(int c);
        case (c)
            1: return 2;  2: return 4;  3: return 3;  4: return 2;  5: return IDIV;
            8: return 2;  9: return 8;  10: return 3; 11: return 2; 12: return SDIV;
            13: return DDIV;
            default: return 1;
        endcase
    endfunction

    function automatic int e_hold(int c);
        case (c)
            2: return 4;  3: return 2;  5: return IDIV; 6: return 2; 7: return 3;
            12: return SDIV; 13: return DDIV;
            default: return 1;
        endcase
    endfunction

    // 0 either integer unit, 1 first integer only, 2 load/store, 3 float
    function automatic int e_kind(int c);
        if (c >= 2 && c <= 5)   return 1;
        if (c == 8 || c == 9)   return 2;
        if (c >= 10 && c <= 13) return 3;
        return 0;
    endfunction

    function automatic int unit_of_kind(int k);
        case (k)
            0: return 1;
            1: return 0;
            2: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int side_lat_of(int s);
        case (s)
            0: return 1;
            2: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic present(input logic v0, input int c0, input logic v1, input int c1,
                           input logic vs, input int sc);
        slot0_vld = v0; slot0_cls = 4'(c0);
        slot1_vld = v1; slot1_cls = 4'(c1);
        side_vld  = vs; side_cls  = 2'(sc);
    endtask

    task automatic idle(input int n);
        present(1'b0, 0, 1'b0, 0, 1'b0, 0);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        #1;
        chk("R1", "slot0_iss idle", int'(slot0_iss), 0);
        chk("R1", "side_iss idle", int'(side_iss), 0);
        chk("R1", "stall idle", int'(stall), 0);
        @(negedge clk);

        // R1: reset clears a long reservation
        present(1'b1, 5, 1'b0, 0, 1'b0, 0);
        @(negedge clk);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        present(1'b1, 4, 1'b0, 0, 1'b0, 0);
        #1;
        chk("R1", "multiply after reset issues", int'(slot0_iss), 1);
        @(negedge clk);

        // R2 R3 R4 R7 R9 R10 R11 R12: every ordered class pair from idle
        for (int c0 = 0; c0 < 16; c0++) begin
            for (int c1 = 0; c1 < 16; c1++) begin
                int k0, k1, eu1, sc;
                bit ei1;
                idle(12);
                sc = (c0 + c1) % 4;
                present(1'b1, c0, 1'b1, c1, 1'b1, sc);
                #1;
                k0 = e_kind(c0);
                k1 = e_kind(c1);
                ei1 = !(k1 != 0 && k1 == k0);
                if (k1 == 0) eu1 = (k0 == 0) ? 0 : 1;
                else         eu1 = unit_of_kind(k1);
                chk("R2", "slot0 issues", int'(slot0_iss), 1);
                chk((k0 == 1) ? "R4" : ((c0 >= 14) ? "R12" : "R3"), "slot0 unit",
                    int'(slot0_unit), unit_of_kind(k0));
                chk("R2", "slot0 latency", int'(slot0_lat), e_lat(c0));
                chk("R7", "slot1 issue", int'(slot1_iss), int'(ei1));
                chk(ei1 ? "R2" : "R11", "slot1 unit", int'(slot1_unit), ei1 ? eu1 : 0);
                chk(ei1 ? "R2" : "R11", "slot1 latency", int'(slot1_lat), ei1 ? e_lat(c1) : 0);
                chk("R10", "stall", int'(stall), int'(!ei1));
                chk("R9", "side issue", int'(side_iss), 1);
                chk("R9", "side unit", int'(side_unit), (sc == 0) ? 5 : 4);
                chk("R9", "side latency", int'(side_lat), side_lat_of(sc));
                @(negedge clk);
            end
        end

        // R5 R6: probe each class's unit at every offset up to one past its hold
        for (int c = 0; c < 16; c++) begin
            for (int k = 1; k <= e_hold(c) + 1; k++) begin
                int u, probe;
                idle(12);
                present(1'b1, c, 1'b0, 0, 1'b0, 0);
                @(negedge clk);
                idle(k - 1);
                u = unit_of_kind(e_kind(c));
                case (u)
                    0: probe = 4;
                    1: probe = 0;
                    2: probe = 8;
                    default: probe = 11;
                endcase
                present(1'b1, probe, 1'b0, 0, 1'b0, 0);
                #1;
                if (u == 1) begin
                    chk("R3", "probe issues", int'(slot0_iss), 1);
                    chk((e_hold(c) == 1) ? "R6" : "R5", "probe integer unit",
                        int'(slot0_unit), (k >= e_hold(c)) ? 1 : 0);
                end else begin
                    chk((e_hold(c) == 1) ? "R6" : "R5", "probe issue",
                        int'(slot0_iss), int'(k >= e_hold(c)));
                end
                @(negedge clk);
            end
        end

        // R9: system unit held for SRU_CYC cycles; branches never wait
        for (int s = 0; s < 4; s++) begin
            for (int k = 1; k <= 3; k++) begin
                idle(12);
                present(1'b0, 0, 1'b0, 0, 1'b1, s);
                #1;
                chk("R9", "side first issue", int'(side_iss), 1);
                @(negedge clk);
                idle(k - 1);
                present(1'b0, 0, 1'b0, 0, 1'b1, 2);
                #1;
                chk("R9", "system follower issue", int'(side_iss), int'(s == 0 || k >= SRUC));
                chk("R10", "system follower stall", int'(stall), int'(!(s == 0 || k >= SRUC)));
                @(negedge clk);
            end
        end

        // R8: older slot blocked keeps the younger one back
        idle(12);
        present(1'b1, 5, 1'b0, 0, 1'b0, 0);
        @(negedge clk);
        present(1'b1, 4, 1'b1, 8, 1'b0, 0);
        #1;
        chk("R8", "older blocked", int'(slot0_iss), 0);
        chk("R8", "younger held", int'(slot1_iss), 0);
        chk("R10", "stall raised", int'(stall), 1);
        @(negedge clk);

        // R8: empty older slot lets the younger one go
        idle(12);
        present(1'b0, 0, 1'b1, 8, 1'b0, 0);
        #1;
        chk("R8", "younger alone issues", int'(slot1_iss), 1);
        chk("R8", "younger alone unit", int'(slot1_unit), 2);
        chk("R10", "no stall", int'(stall), 0);
        @(negedge clk);

        // R3: integer unit 1 busy, simple op falls to unit 0, second one stalls
        idle(12);
        present(1'b1, 7, 1'b0, 0, 1'b0, 0);
        @(negedge clk);
        present(1'b1, 0, 1'b1, 1, 1'b0, 0);
        #1;
        chk("R3", "fallback unit", int'(slot0_unit), 0);
        chk("R3", "no second integer unit", int'(slot1_iss), 0);
        @(negedge clk);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule